// File: doc/BRIEF.md
# Four-Channel Staged-Update PWM Generator

This block produces four independent pulse-width-modulated outputs from a single reference clock. Software programs each channel through a small memory-mapped port. The port has a byte address, a write strobe, write data and combinational read data. Each channel divides the clock twice. A prescaler stretches every count, and a period counter sets how many stretched counts make up one period. A high-time field sets how long the pin stays high at the start of each period.

New settings are written into staging registers first, while the channel keeps running on its active copy. The staged values move into the active copy only on request, and only at the point where one period ends and the next begins. The running period therefore always finishes intact. Turning a channel off is handled the same way: the current period runs to its end, the pin then goes low, and the staged divider fields are set to fixed idle values.

Top module: `pwm4_ctrl`

## Requirements
- R1: Channel i uses byte offsets 8*i (word A) and 8*i+4 (word B); address bits [1:0] are ignored. Word A holds the period divider in bits [15:0] and the high time in bits [31:16]. Word B holds the prescale in bits [15:0], the apply request in bit 30 and the run enable in bit 31. All other bits read as 0, and a read returns the stored staging fields.
- R2: A running period lasts (prescale+1)*(divider+1) clock cycles. The pin is high for the first high*(prescale+1) cycles of the period and low for the rest, so the pin rises only at the start of a period.
- R3: If high*(prescale+1) is at least the period length, the pin stays high for the whole period. If high is 0, the pin stays low.
- R4: When enable is set on an idle channel, the staged values are loaded on the next clock edge and a new period begins. The pin goes high in the cycle after that edge if high is nonzero.
- R5: Writing staging fields without an apply request leaves the running waveform unchanged.
- R6: An apply request takes effect at the next period boundary. The current period completes with the old values, and the next period uses the staged ones.
- R7: The apply bit reads as 1 from the write that sets it until the staged values are transferred, and then clears by itself.
- R8: Clearing enable lets the current period finish. The channel then stops and holds its pin low.
- R9: When a channel stops, its staged prescale becomes 0 and its staged divider becomes 1. The staged high time is kept.
- R10: A synchronous reset clears every register and counter and drives all pins low.
- R11: Each channel's waveform depends only on its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The assertions assume that software writes do not land in the cycle where a channel stops. A write in that cycle would overwrite the idle divider values that R9 expects. The assertions also assume that reset is held for at least one edge. The stimulus keeps within these limits by making all writes from tasks that change the bus only on the falling edge. It also places each disable long before the end of a period, and the checked window after a stop contains no writes. Every output is compared with a behavioural model on each clock.

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = $clog2(NCH) + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  output logic [NCH-1:0] pwm_out
);
  localparam int CHW = AW - 3;
  localparam logic [CW-1:0] DIV_IDLE = CW'(1);

  logic [NCH-1:0][31:0] r0_v, r1_v;
  logic [NCH-1:0]       run_v, bnd_v, upd_v;
  logic [CHW-1:0]       sel;
  logic                 unused_lsb;

  assign sel        = addr[AW-1:3];
  assign unused_lsb = ^addr[1:0];
  assign rd_data    = (int'(sel) < NCH) ? (addr[2] ? r1_v[sel] : r0_v[sel]) : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] div_s, hi_s, pre_s, div_a, hi_a, pre_a, pcnt, tcnt;
    logic en_s, upd_s, run;
    logic hit, tick_end, bnd;

    assign hit      = wr_en && (sel == CHW'(c));
    assign tick_end = (pcnt == pre_a);
    assign bnd      = run && tick_end && (tcnt == div_a);

    always_ff @(posedge clk) begin
      if (rst) begin
        div_s <= '0; hi_s <= '0; pre_s <= '0;
        div_a <= '0; hi_a <= '0; pre_a <= '0;
        pcnt  <= '0; tcnt <= '0;
        en_s  <= 1'b0; upd_s <= 1'b0; run <= 1'b0;
      end else begin
        if (run) begin
          if (bnd) begin
            pcnt <= '0;
            tcnt <= '0;
            if (!en_s) begin
              run   <= 1'b0;
              pre_s <= '0;
              div_s <= DIV_IDLE;
            end else if (upd_s) begin
              div_a <= div_s; hi_a <= hi_s; pre_a <= pre_s;
              upd_s <= 1'b0;
            end
          end else if (tick_end) begin
            pcnt <= '0;
            tcnt <= tcnt + 1'b1;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end else if (en_s) begin
          div_a <= div_s; hi_a <= hi_s; pre_a <= pre_s;
          upd_s <= 1'b0;
          run   <= 1'b1;
          pcnt  <= '0;
          tcnt  <= '0;
        end
        if (hit) begin
          if (!addr[2]) begin
            div_s <= wr_data[CW-1:0];
            hi_s  <= wr_data[16 +: CW];
          end else begin
            pre_s <= wr_data[CW-1:0];
            en_s  <= wr_data[31];
            if (wr_data[30]) upd_s <= 1'b1;
          end
        end
      end
    end

    assign pwm_out[c] = run && (tcnt < hi_a);
    assign r0_v[c]    = {16'(hi_s), 16'(div_s)};
    assign r1_v[c]    = {en_s, upd_s, 14'b0, 16'(pre_s)};
    assign run_v[c]   = run;
    assign bnd_v[c]   = bnd;
    assign upd_v[c]   = upd_s;
  end
endmodule

// File: rtl/pwm4_ctrl_chk.sv
module pwm4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [NCH-1:0]       pwm_out,
  input logic [NCH-1:0]       run_v,
  input logic [NCH-1:0]       bnd_v,
  input logic [NCH-1:0]       upd_v,
  input logic [NCH-1:0][31:0] r0_v,
  input logic [NCH-1:0][31:0] r1_v
);
  // R10
  reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pwm_out == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    // R2
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(pwm_out[c])) |-> ($past(bnd_v[c]) || !$past(run_v[c])));
    // R7
    apply_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(upd_v[c])) |-> ($past(bnd_v[c]) || !$past(run_v[c])));
    // R8
    stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(run_v[c])) |-> $past(bnd_v[c]));
    // R9
    idle_fields_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(run_v[c]) && !$past(wr_en)) |->
        (r0_v[c][15:0] == 16'd1 && r1_v[c][15:0] == 16'd0));
  end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .pwm_out(pwm_out),
  .run_v(run_v), .bnd_v(bnd_v), .upd_v(upd_v), .r0_v(r0_v), .r1_v(r1_v)
);

// File: tb/pwm4_ctrl_tb.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb;
  localparam int NCH = 4;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  wire  [NCH-1:0] pwm_out;
  int errors = 0, checks = 0;
  string phase = "R10";

  always #2 clk = ~clk;

  pwm4_ctrl u_dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
                   .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

  longint m_sdiv[NCH], m_shi[NCH], m_spre[NCH], m_adiv[NCH], m_ahi[NCH], m_apre[NCH], m_pos[NCH];
  bit m_en[NCH], m_upd[NCH], m_run[NCH];
  longint len;

  function automatic bit m_out(int c);
    return m_run[c] && (m_pos[c] < m_ahi[c] * (m_apre[c] + 1));
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m_sdiv[c] = 0; m_shi[c] = 0; m_spre[c] = 0; m_adiv[c] = 0; m_ahi[c] = 0;
        m_apre[c] = 0; m_pos[c] = 0; m_en[c] = 0; m_upd[c] = 0; m_run[c] = 0;
      end else begin
        if (m_run[c]) begin
          len = (m_apre[c] + 1) * (m_adiv[c] + 1);
          if (m_pos[c] == len - 1) begin
            m_pos[c] = 0;
            if (!m_en[c]) begin
              m_run[c] = 0; m_spre[c] = 0; m_sdiv[c] = 1;
            end else if (m_upd[c]) begin
              m_adiv[c] = m_sdiv[c]; m_ahi[c] = m_shi[c]; m_apre[c] = m_spre[c]; m_upd[c] = 0;
            end
          end else m_pos[c]++;
        end else if (m_en[c]) begin
          m_adiv[c] = m_sdiv[c]; m_ahi[c] = m_shi[c]; m_apre[c] = m_spre[c];
          m_upd[c] = 0; m_run[c] = 1; m_pos[c] = 0;
        end
        if (wr_en && int'(addr[4:3]) == c) begin
          if (!addr[2]) begin
            m_sdiv[c] = wr_data[15:0]; m_shi[c] = wr_data[31:16];
          end else begin
            m_spre[c] = wr_data[15:0]; m_en[c] = wr_data[31];
            if (wr_data[30]) m_upd[c] = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (pwm_out[c] !== m_out(c)) begin
        errors++;
        $display("FAIL %s ch%0d pwm_out actual=%b expected=%b at %0t", phase, c, pwm_out[c], m_out(c), $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int c, bit hi_word, logic [31:0] d);
    @(negedge clk);
    addr = 5'(c * 8 + (hi_word ? 4 : 0)); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int c, bit hi_word);
    logic [31:0] exp;
    @(negedge clk);
    addr = 5'(c * 8 + (hi_word ? 4 : 0));
    #1;
    exp = hi_word ? {m_en[c], m_upd[c], 14'b0, 16'(m_spre[c])} : {16'(m_shi[c]), 16'(m_sdiv[c])};
    chk({phase, " read"}, rd_data, exp);
  endtask

  task automatic count_high(int c, int n, output int high);
    high = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (pwm_out[c]) high++;
    end
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0); chk("R10 word A", rd_data, 32'h0);
      rd(c, 1); chk("R10 word B", rd_data, 32'h0);
    end
    phase = "R1";
    wr(0, 0, {16'd3, 16'd9});
    wr(0, 1, 32'h0000_0001);
    wr(3, 0, 32'h0005_0007);
    rd(0, 0); chk("R1 ch0 word A", rd_data, 32'h0003_0009);
    rd(0, 1); chk("R1 ch0 word B", rd_data, 32'h0000_0001);
    rd(3, 0); chk("R1 ch3 word A", rd_data, 32'h0005_0007);
    rd(2, 0); chk("R1 ch2 untouched", rd_data, 32'h0);
    phase = "R4";
    wr(0, 1, 32'h8000_0001);
    repeat (70) @(negedge clk);
    phase = "R2";
    count_high(0, 20, h); chk("R2 high cycles per period", 32'(h), 32'd6);
    phase = "R3";
    wr(1, 0, {16'd20, 16'd4});
    wr(1, 1, 32'h8000_0000);
    wr(2, 0, {16'd0, 16'd3});
    wr(2, 1, 32'h8000_0000);
    repeat (3) @(negedge clk);
    count_high(1, 5, h); chk("R3 full high", 32'(h), 32'd5);
    count_high(2, 4, h); chk("R3 zero high", 32'(h), 32'd0);
    phase = "R5";
    wr(0, 0, {16'd1, 16'd4});
    repeat (40) @(negedge clk);
    count_high(0, 20, h); chk("R5 waveform unchanged", 32'(h), 32'd6);
    phase = "R7";
    wr(0, 1, 32'hC000_0000);
    rd(0, 1);
    repeat (25) @(negedge clk);
    rd(0, 1); chk("R7 apply bit cleared", rd_data, 32'h8000_0000);
    phase = "R6";
    count_high(0, 5, h); chk("R6 new settings in use", 32'(h), 32'd1);
    phase = "R11";
    wr(3, 1, 32'h8000_0002);
    repeat (50) @(negedge clk);
    count_high(3, 24, h); chk("R11 ch3 own waveform", 32'(h), 32'd15);
    count_high(1, 5, h);  chk("R11 ch1 unaffected", 32'(h), 32'd5);
    phase = "R8";
    wr(0, 1, 32'h0000_0000);
    repeat (12) @(negedge clk);
    count_high(0, 10, h); chk("R8 stopped low", 32'(h), 32'd0);
    phase = "R9";
    rd(0, 0); chk("R9 divider idle value", rd_data, 32'h0001_0001);
    rd(0, 1); chk("R9 prescale idle value", rd_data, 32'h0);
    phase = "R10";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 outputs low after reset", 32'(pwm_out), 32'h0);
    rd(3, 1); chk("R10 registers cleared", rd_data, 32'h0);
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule